// File: doc/BRIEF.md
# Indexed Voice Register Access Port

This block is the host-facing register port of a multi-voice wavetable synthesizer. The host sees four byte-addressed locations: a voice selector, a function selector, and a 16-bit data window. The window can be used as one 16-bit word, or as two separate byte lanes (low and high). The selected voice and function together pick one 16-bit word in a per-voice register array. A byte write changes only its own lane of that word.

The same data window also reaches two global registers: the active-voice count and a control register. Bit 0 of the control register is a run bit. While it is low, the voice array cannot be written. Writing the control register with the run bit low puts the block into a known state and sends a one-cycle clear pulse to the neighbouring status logic. Voice registers are written through one range of function codes and read through a second range that points at the same words.

Top module: `vrp_voice_port`

## Requirements
- R1: The host locations are 0 = voice selector, 1 = function selector, 2 = data low lane (also used for word accesses), 3 = data high lane. The addressed voice word is indexed by the low 5 bits of the voice selector and the low 4 bits of the function selector. Selector bits above those are ignored for addressing, so voice 0x25 reaches the same words as voice 5.
- R2: Function codes 0x00–0x0D write voice words and codes 0x80–0x8D read the same words. A read made with a write code returns 0xFFFF, and a write made with any other code does not touch the array.
- R3: A byte write to location 2 replaces bits 7:0 and keeps bits 15:8. A byte write to location 3 places data bits 7:0 into bits 15:8 and keeps bits 7:0. A word write to location 2 or 3 replaces all 16 bits.
- R4: A byte read from location 2 returns bits 7:0 of the word, zero-extended. A byte read from location 3 returns bits 15:8, zero-extended. A word read returns all 16 bits.
- R5: Voice writes are ignored while control bit 0 is 0.
- R6: A write with code 0x0E stores data bits 7:0 as the voice count. A read with code 0x8E returns the count, zero-extended.
- R7: A write with code 0x4C stores data bits 7:0 in the control register (`ctl_reg`). If data bit 0 is 0, the same write also sets the count to 0xCD, clears control bits 1 and 2, and raises `glob_clear` for exactly the next cycle.
- R8: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read. Reads of any unsupported code (for example 0x4C or 0x8F) return 0xFFFF.
- R9: Reads of location 0 and location 1 return the stored 8-bit selectors, zero-extended.
- R10: After reset, `bus_rdata`, `ctl_reg`, both selectors and every voice word are 0, the count is 0xCD, and `glob_clear` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Host location (0 voice sel, 1 function sel, 2 low/word, 3 high) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data (byte accesses use bits 7:0) |
| bus_rdata | output | 16 | Registered read data |
| ctl_reg | output | 8 | Current control register |
| glob_clear | output | 1 | One-cycle pulse after a write that clears the control run bit |

## Verification
The bench builds the block with its default parameters: 5 voice-index bits, 4 function-index bits and 14 voice functions. With these values the top voice (31) and the last voice function (0x0D) can be reached directly. Because the voice selector is 8 bits wide, its upper bits can be driven to exercise aliasing. Code 0x0E sits right after the last voice function, so the boundary between the voice range and the count register can be tested, as can codes just past the read range (0x8F).

// File: rtl/vrp_pkg.sv
package vrp_pkg;

  typedef enum logic [1:0] {
    LOC_VSEL = 2'd0,
    LOC_FSEL = 2'd1,
    LOC_LO   = 2'd2,
    LOC_HI   = 2'd3
  } loc_e;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_VOICE,
    RD_CNT,
    RD_VSEL,
    RD_FSEL
  } rd_kind_e;

  // merge write data into a stored word according to access size and lane
  function automatic logic [15:0] lane_merge(input logic [15:0] old_w,
                                             input logic [15:0] wd,
                                             input logic        is_word,
                                             input logic        hi_lane);
    if (is_word)      return wd;
    else if (hi_lane) return {wd[7:0], old_w[7:0]};
    else              return {old_w[15:8], wd[7:0]};
  endfunction

  // pick the returned value from a stored word according to size and lane
  function automatic logic [15:0] lane_pick(input logic [15:0] w,
                                            input logic        is_word,
                                            input logic        hi_lane);
    if (is_word)      return w;
    else if (hi_lane) return {8'h00, w[15:8]};
    else              return {8'h00, w[7:0]};
  endfunction

endpackage

// File: rtl/vrp_decode.sv
module vrp_decode
  import vrp_pkg::*;
#(
  parameter int FUNC_BITS = 4,
  parameter int NUM_FUNCS = 14,
  parameter logic [7:0] RD_BASE  = 8'h80,
  parameter logic [7:0] CNT_CODE = 8'h0E,
  parameter logic [7:0] CTL_CODE = 8'h4C
) (
  input  logic [7:0] func_sel,
  input  logic [1:0] loc,
  input  logic       rd,
  input  logic       wr,
  output logic       voice_hit,
  output logic       cnt_we,
  output logic       ctl_we,
  output rd_kind_e   rd_kind
);
  localparam int UPPER = 8 - FUNC_BITS;
  localparam logic [7:0] CNT_RD = CNT_CODE | RD_BASE;

  logic data_loc;
  logic wr_code_ok;
  logic rd_code_ok;

  assign data_loc   = loc[1];
  assign wr_code_ok = (func_sel[7:FUNC_BITS] == '0) &&
                      (int'(func_sel[FUNC_BITS-1:0]) < NUM_FUNCS);
  assign rd_code_ok = (func_sel[7:FUNC_BITS] == RD_BASE[7:FUNC_BITS]) &&
                      (int'(func_sel[FUNC_BITS-1:0]) < NUM_FUNCS);

  assign voice_hit = wr && data_loc && wr_code_ok;
  assign cnt_we    = wr && data_loc && (func_sel == CNT_CODE);
  assign ctl_we    = wr && data_loc && (func_sel == CTL_CODE);

  always_comb begin
    rd_kind = RD_NONE;
    if (rd) begin
      unique case (loc_e'(loc))
        LOC_VSEL: rd_kind = RD_VSEL;
        LOC_FSEL: rd_kind = RD_FSEL;
        default: begin
          if (rd_code_ok)              rd_kind = RD_VOICE;
          else if (func_sel == CNT_RD) rd_kind = RD_CNT;
          else                         rd_kind = RD_NONE;
        end
      endcase
    end
  end

  logic unused_upper;
  assign unused_upper = (UPPER < 0);
endmodule

// File: rtl/vrp_voice_store.sv
module vrp_voice_store
  import vrp_pkg::*;
#(
  parameter int VOICE_BITS = 5,
  parameter int FUNC_BITS  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [VOICE_BITS-1:0] voice,
  input  logic [FUNC_BITS-1:0]  func,
  input  logic [15:0]           wdata,
  input  logic                  is_word,
  input  logic                  hi_lane,
  output logic [15:0]           rd_word
);
  localparam int IDX_W = VOICE_BITS + FUNC_BITS;
  localparam int DEPTH = 1 << IDX_W;

  logic [15:0] mem [DEPTH];
  logic [IDX_W-1:0] idx;

  assign idx     = {voice, func};
  assign rd_word = mem[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= lane_merge(mem[idx], wdata, is_word, hi_lane);
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && is_word) |=> (mem[$past(idx)] == $past(wdata)))
    else $error("word write lost"); // R3
endmodule

// File: rtl/vrp_voice_port.sv
module vrp_voice_port
  import vrp_pkg::*;
#(
  parameter int VOICE_BITS = 5,
  parameter int FUNC_BITS  = 4,
  parameter int NUM_FUNCS  = 14,
  parameter logic [7:0] CNT_RESET = 8'hCD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic        bus_word,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic [7:0]  ctl_reg,
  output logic        glob_clear
);
  localparam logic [7:0] CLR_MASK = 8'h06;

  logic [7:0]  voice_sel_q, func_sel_q, cnt_q, ctl_q;
  logic [15:0] rdata_q;
  logic        clr_q;

  logic        voice_hit, cnt_we, ctl_we, voice_we;
  rd_kind_e    rd_kind;
  logic [15:0] vstore_word;
  logic        hi_lane;

  assign hi_lane = (bus_addr == LOC_HI);

  vrp_decode #(
    .FUNC_BITS(FUNC_BITS),
    .NUM_FUNCS(NUM_FUNCS)
  ) u_dec (
    .func_sel (func_sel_q),
    .loc      (bus_addr),
    .rd       (bus_rd),
    .wr       (bus_wr),
    .voice_hit(voice_hit),
    .cnt_we   (cnt_we),
    .ctl_we   (ctl_we),
    .rd_kind  (rd_kind)
  );

  // run bit gates every voice write
  assign voice_we = voice_hit && ctl_q[0];

  vrp_voice_store #(
    .VOICE_BITS(VOICE_BITS),
    .FUNC_BITS (FUNC_BITS)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (voice_we),
    .voice  (voice_sel_q[VOICE_BITS-1:0]),
    .func   (func_sel_q[FUNC_BITS-1:0]),
    .wdata  (bus_wdata),
    .is_word(bus_word),
    .hi_lane(hi_lane),
    .rd_word(vstore_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      voice_sel_q <= '0;
      func_sel_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == LOC_VSEL) voice_sel_q <= bus_wdata[7:0];
      if (bus_addr == LOC_FSEL) func_sel_q  <= bus_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_RESET;
      ctl_q <= '0;
      clr_q <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      if (cnt_we) cnt_q <= bus_wdata[7:0];
      if (ctl_we) begin
        if (bus_wdata[0]) begin
          ctl_q <= bus_wdata[7:0];
        end else begin
          ctl_q <= bus_wdata[7:0] & ~CLR_MASK;
          cnt_q <= CNT_RESET;
          clr_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      unique case (rd_kind)
        RD_VSEL:  rdata_q <= {8'h00, voice_sel_q};
        RD_FSEL:  rdata_q <= {8'h00, func_sel_q};
        RD_VOICE: rdata_q <= lane_pick(vstore_word, bus_word, hi_lane);
        RD_CNT:   rdata_q <= {8'h00, cnt_q};
        default:  rdata_q <= 16'hFFFF;
      endcase
    end
  end

  assign bus_rdata  = rdata_q;
  assign ctl_reg    = ctl_q;
  assign glob_clear = clr_q;

  AST_WRITE_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({voice_hit, cnt_we, ctl_we}))
    else $error("write decode overlap"); // R2
  AST_BLOCKED_VOICE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_hit && !ctl_q[0]) |=> $stable(vstore_word))
    else $error("voice write while run bit low"); // R5
  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    glob_clear |-> (cnt_q == CNT_RESET && ctl_q[2:1] == 2'b00))
    else $error("clear state wrong"); // R7
  AST_UNSUPPORTED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rd_kind == RD_NONE) |=> (bus_rdata == 16'hFFFF))
    else $error("unsupported read value"); // R8
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata))
    else $error("read data moved"); // R8
  AST_WORD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rd_kind == RD_VOICE && bus_word) |=> (bus_rdata == $past(vstore_word)))
    else $error("word read mismatch"); // R4
endmodule

// File: tb/tb_vrp_voice_port.sv
module tb_vrp_voice_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  ctl_reg;
  logic        glob_clear;

  int total = 0, bad = 0;
  string cur_req = "R10";
  bit model_live = 0;

  always #2 clk = ~clk;  // 250 MHz

  vrp_voice_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_word(bus_word), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ctl_reg(ctl_reg), .glob_clear(glob_clear)
  );

  // behavioural reference
  int m_mem [32][16];
  int m_vs, m_fs, m_cnt, m_ctl, m_rd, m_clr;

  task automatic model_reset();
    foreach (m_mem[v, f]) m_mem[v][f] = 0;
    m_vs = 0; m_fs = 0; m_cnt = 'hCD; m_ctl = 0; m_rd = 0; m_clr = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int v, f, w, d, nrd;
      v = m_vs % 32; f = m_fs % 16; d = bus_wdata;
      nrd = m_rd;
      m_clr = 0;
      if (bus_rd) begin
        if (bus_addr == 0) nrd = m_vs;
        else if (bus_addr == 1) nrd = m_fs;
        else if (m_fs >= 'h80 && m_fs <= 'h8D) begin
          w = m_mem[v][f];
          nrd = bus_word ? w : (bus_addr == 3 ? w / 256 : w % 256);
        end else if (m_fs == 'h8E) nrd = m_cnt;
        else nrd = 'hFFFF;
      end
      if (bus_wr) begin
        if (bus_addr == 0) m_vs = d % 256;
        else if (bus_addr == 1) m_fs = d % 256;
        else if (m_fs <= 'h0D) begin
          if (m_ctl % 2 == 1) begin
            w = m_mem[v][f];
            if (bus_word) w = d;
            else if (bus_addr == 3) w = (d % 256) * 256 + w % 256;
            else w = (w / 256) * 256 + d % 256;
            m_mem[v][f] = w;
          end
        end else if (m_fs == 'h0E) m_cnt = d % 256;
        else if (m_fs == 'h4C) begin
          m_ctl = d % 256;
          if (d % 2 == 0) begin
            m_ctl = m_ctl & ~6; m_cnt = 'hCD; m_clr = 1;
          end
        end
      end
      m_rd = nrd;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_live && rst_n) begin
      check(cur_req, "model rdata", int'(bus_rdata), m_rd);
      check(cur_req, "model ctl_reg", int'(ctl_reg), m_ctl);
      check(cur_req, "model glob_clear", int'(glob_clear), m_clr);
    end
  end

  task automatic wr(input logic [1:0] a, input logic w, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_word = w; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic w, input int exp, input string req);
    @(negedge clk);
    bus_addr = a; bus_word = w; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, "read", int'(bus_rdata), exp);
  endtask

  task automatic sel(input int v, input int f);
    wr(2'd0, 1'b0, 16'(v));
    wr(2'd1, 1'b0, 16'(f));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model_live = 1;
    cur_req = "R10";
    check("R10", "reset rdata", int'(bus_rdata), 0);
    check("R10", "reset ctl", int'(ctl_reg), 0);
    check("R10", "reset clear", int'(glob_clear), 0);
    sel(0, 'h8E);
    rd_exp(2'd2, 1'b1, 'hCD, "R10");
    sel(31, 'h8D);
    rd_exp(2'd2, 1'b1, 0, "R10");

    cur_req = "R5";
    sel(3, 'h02);
    wr(2'd2, 1'b1, 16'h5555);
    wr(2'd1, 1'b0, 16'h82);
    rd_exp(2'd2, 1'b1, 0, "R5");

    cur_req = "R7";
    sel(3, 'h4C);
    wr(2'd2, 1'b0, 16'h0007);
    check("R7", "ctl set with run bit", int'(ctl_reg), 7);

    cur_req = "R1";
    sel(3, 'h02);
    wr(2'd2, 1'b1, 16'hBEEF);
    wr(2'd1, 1'b0, 16'h82);
    rd_exp(2'd2, 1'b1, 'hBEEF, "R1");
    sel(4, 'h82);
    rd_exp(2'd2, 1'b1, 0, "R1");

    cur_req = "R3";
    sel(3, 'h02);
    wr(2'd2, 1'b0, 16'hAA12);
    wr(2'd1, 1'b0, 16'h82);
    rd_exp(2'd2, 1'b1, 'hBE12, "R3");
    wr(2'd1, 1'b0, 16'h02);
    wr(2'd3, 1'b0, 16'h7734);
    wr(2'd1, 1'b0, 16'h82);
    rd_exp(2'd2, 1'b1, 'h3412, "R3");
    wr(2'd1, 1'b0, 16'h02);
    wr(2'd3, 1'b1, 16'hC0DE);
    wr(2'd1, 1'b0, 16'h82);
    rd_exp(2'd3, 1'b1, 'hC0DE, "R3");

    cur_req = "R4";
    rd_exp(2'd2, 1'b0, 'h00DE, "R4");
    rd_exp(2'd3, 1'b0, 'h00C0, "R4");

    cur_req = "R1";
    sel('h25, 'h0D);
    wr(2'd2, 1'b1, 16'hA5A5);
    sel(5, 'h8D);
    rd_exp(2'd2, 1'b1, 'hA5A5, "R1");

    cur_req = "R2";
    sel(5, 'h0D);
    rd_exp(2'd2, 1'b1, 'hFFFF, "R2");
    sel(6, 'h0F);
    wr(2'd2, 1'b1, 16'h1111);
    rd_exp(2'd2, 1'b1, 'hFFFF, "R8");
    sel(6, 'h8F);
    rd_exp(2'd2, 1'b1, 'hFFFF, "R8");
    sel(6, 'h4C);
    rd_exp(2'd2, 1'b1, 'hFFFF, "R8");

    cur_req = "R6";
    sel(6, 'h0E);
    wr(2'd2, 1'b1, 16'h331C);
    wr(2'd1, 1'b0, 16'h8E);
    rd_exp(2'd2, 1'b1, 'h001C, "R6");

    cur_req = "R9";
    rd_exp(2'd0, 1'b0, 'h0006, "R9");
    rd_exp(2'd1, 1'b0, 'h008E, "R9");
    cur_req = "R8";
    repeat (3) @(negedge clk);
    check("R8", "rdata hold", int'(bus_rdata), 'h008E);

    cur_req = "R7";
    wr(2'd1, 1'b0, 16'h4C);
    @(negedge clk);
    bus_addr = 2'd2; bus_word = 1'b1; bus_wdata = 16'h00F6; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R7", "clear pulse", int'(glob_clear), 1);
    check("R7", "ctl bits 1,2 cleared", int'(ctl_reg), 'hF0);
    @(negedge clk);
    check("R7", "clear pulse one cycle", int'(glob_clear), 0);
    wr(2'd1, 1'b0, 16'h8E);
    rd_exp(2'd2, 1'b1, 'h00CD, "R7");

    cur_req = "R5";
    sel(5, 'h0D);
    wr(2'd2, 1'b1, 16'h0BAD);
    wr(2'd1, 1'b0, 16'h8D);
    rd_exp(2'd2, 1'b1, 'hA5A5, "R5");

    sel(0, 'h4C);
    wr(2'd2, 1'b0, 16'h0001);
    cur_req = "R1";
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      @(negedge clk);
      bus_addr = 2'($urandom_range(0, 3));
      bus_word = 1'($urandom_range(0, 1));
      if (op < 2) begin
        bus_addr = 2'd0; bus_wdata = 16'($urandom_range(0, 255)); bus_wr = 1'b1;
      end else if (op < 4) begin
        bus_addr = 2'd1;
        bus_wdata = 16'($urandom_range(0, 1) ? $urandom_range(0, 15) : $urandom_range('h80, 'h8F));
        bus_wr = 1'b1;
      end else if (op < 7) begin
        bus_wdata = 16'($urandom_range(0, 65535)); bus_wr = 1'b1;
        if (bus_addr < 2) bus_wr = 1'b0;
      end else begin
        bus_rd = 1'b1;
      end
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
    end

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule